// File: doc/BRIEF.md
# Clocked Serial Memory Streamer

This block reads a 128-byte storage array in a loop and sends its contents one bit at a time on a shared, open-drain style data line. An external transmit clock sets the pace, and no command protocol is involved. Each rising edge of that clock moves the stream forward by one bit slot. The transmit clock is sampled in the system clock domain and edge-detected there; it never clocks any flop.

After reset, the first nine transmit clock edges are used for synchronisation, and the line stays released during them. Streaming then starts with the most significant bit of the byte at address 00h. Each byte takes nine slots: eight data bits, most significant first, and then one released null slot. Addresses go up by one and wrap from 7Fh to 00h. A mode controller gates the block through an enable input. Dropping the enable releases the line at once and freezes the stream. Raising it again restarts the stream at the MSB of address 00h, without a second synchronisation interval.

Top module: `romstream_tx`

## Requirements
- R1: After reset, the first nine rising edges of `tx_clk` leave `sda_oe` low (line released).
- R2: On the tenth rising edge of `tx_clk` after reset, `sda_oe` goes high and `sda_out` carries bit 7 of the byte at address 0.
- R3: `sda_out`, `sda_oe` and `mem_addr` change only in response to a rising edge of `tx_clk`. The new value is present within three `clk` cycles of that edge. A `tx_clk` held high produces exactly one step.
- R4: A byte is sent in eight consecutive slots with `sda_oe` high, bit 7 first and bit 0 last.
- R5: The ninth slot of every byte is a null slot with `sda_oe` low.
- R6: `mem_addr` holds the address of the byte being sent and goes up by one at each null slot, wrapping from 127 to 0. `mem_rdata` is expected one `clk` cycle after `mem_addr`, as from a synchronous array.
- R7: While `stream_en` is low, `sda_oe` is low in the same cycle. `tx_clk` edges have no effect, and `mem_addr` holds its value.
- R8: After `stream_en` rises, the next `tx_clk` rising edge drives bit 7 of address 0 with `sda_oe` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| stream_en | input | 1 | Streaming permitted, from the mode controller |
| tx_clk | input | 1 | External transmit clock, sampled asynchronously |
| mem_addr | output | 7 | Read address to the storage array |
| mem_rdata | input | 8 | Registered read data from the storage array |
| sda_out | output | 1 | Bit value for the shared data line |
| sda_oe | output | 1 | Drive enable for the shared data line |

## Verification
On every cycle, the assertions check the following. The line stays released until synchronisation is complete. Outputs and address stay still when no synchronised edge is present. The address freezes while disabled, and every address move is either a step of one or a return to zero. Only the bench scenarios can show the actual bit values and their order: the tenth-edge start, MSB-first order, the null slot and the 7Fh wrap all depend on the memory contents and on counting edges. The same holds for the restart at address 00h after re-enable.

// File: rtl/romstream_pkg.sv
package romstream_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = DATA_W + 1;
  localparam int POS_W      = $clog2(FRAME_BITS);

  // next byte address, wrapping at the array size
  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  // bit sent in data slot pos (slot 0 carries the MSB)
  function automatic logic pick_bit(input logic [DATA_W-1:0] b, input int pos);
    return b[DATA_W-1-pos];
  endfunction
endpackage

// File: rtl/romstream_tickdet.sv
module romstream_tickdet #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic tick
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= raw_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign tick = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/romstream_seq.sv
module romstream_seq
  import romstream_pkg::*;
#(
  parameter int SYNC_TICKS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr,
  output logic              bit_q,
  output logic              oe_q,
  output logic              sync_done,
  output logic              restart
);
  localparam int SYNC_W = $clog2(SYNC_TICKS + 1);

  logic [SYNC_W-1:0] sync_cnt;
  logic [POS_W-1:0]  pos;
  logic [DATA_W-1:0] shreg;
  logic              en_q;

  assign restart   = en & ~en_q;
  assign sync_done = (sync_cnt == SYNC_W'(SYNC_TICKS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt <= '0;
      pos      <= '0;
      addr     <= '0;
      shreg    <= '0;
      bit_q    <= 1'b1;
      oe_q     <= 1'b0;
      en_q     <= 1'b1;
    end else begin
      en_q <= en;
      if (!en) begin
        oe_q <= 1'b0;
      end else if (restart) begin
        sync_cnt <= SYNC_W'(SYNC_TICKS);
        pos      <= '0;
        addr     <= '0;
        oe_q     <= 1'b0;
      end else if (tick) begin
        if (!sync_done) begin
          sync_cnt <= sync_cnt + SYNC_W'(1);
        end else if (pos == '0) begin
          shreg <= rdata;
          bit_q <= pick_bit(rdata, 0);
          oe_q  <= 1'b1;
          pos   <= POS_W'(1);
        end else if (pos < POS_W'(DATA_W)) begin
          bit_q <= pick_bit(shreg, int'(pos));
          pos   <= pos + POS_W'(1);
        end else begin
          bit_q <= 1'b1;
          oe_q  <= 1'b0;
          pos   <= '0;
          addr  <= next_addr(addr);
        end
      end
    end
  end
endmodule

// File: rtl/romstream_tx.sv
module romstream_tx
  import romstream_pkg::*;
#(
  parameter int SYNC_TICKS  = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stream_en,
  input  logic              tx_clk,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              sda_out,
  output logic              sda_oe
);
  logic tick_w;
  logic restart_w;
  logic sync_done_w;
  logic oe_q_w;

  romstream_tickdet #(.STAGES(SYNC_STAGES)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (tx_clk),
    .tick   (tick_w)
  );

  romstream_seq #(.SYNC_TICKS(SYNC_TICKS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (stream_en),
    .tick      (tick_w),
    .rdata     (mem_rdata),
    .addr      (mem_addr),
    .bit_q     (sda_out),
    .oe_q      (oe_q_w),
    .sync_done (sync_done_w),
    .restart   (restart_w)
  );

  // release the line in the same cycle the enable drops
  assign sda_oe = oe_q_w & stream_en;
endmodule

// File: rtl/romstream_tx_chk.sv
module romstream_tx_chk
  import romstream_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stream_en,
  input logic              tick,
  input logic              restart,
  input logic              sync_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              sda_out,
  input logic              sda_oe
);
  AST_SYNC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_done |-> !sda_oe); // R1

  AST_BIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sda_out)); // R3

  AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !restart) |=> $stable(mem_addr)); // R3

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_addr != $past(mem_addr)) |->
      ((mem_addr == ADDR_W'($past(mem_addr) + 1)) || (mem_addr == '0))); // R6

  AST_FREEZE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !stream_en |=> $stable(mem_addr)); // R7

  AST_OE_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(tick)); // R3
endmodule

bind romstream_tx romstream_tx_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stream_en (stream_en),
  .tick      (tick_w),
  .restart   (restart_w),
  .sync_done (sync_done_w),
  .mem_addr  (mem_addr),
  .sda_out   (sda_out),
  .sda_oe    (sda_oe)
);

// File: tb/romstream_tx_test.sv
module romstream_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stream_en = 1'b1;
  logic       tx_clk = 1'b0;
  logic [6:0] mem_addr;
  logic [7:0] mem_rdata;
  logic       sda_out;
  logic       sda_oe;

  int checks = 0;
  int errors = 0;

  // model state
  int m_sync = 9;
  int m_pos  = 0;
  int m_addr = 0;
  int m_first = 1;
  logic  e_oe;
  logic  e_bit;
  string e_req;

  always #10 clk = ~clk;

  romstream_tx uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .stream_en (stream_en),
    .tx_clk    (tx_clk),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .sda_out   (sda_out),
    .sda_oe    (sda_oe)
  );

  function automatic logic [7:0] mem_val(input int a);
    return 8'(((a * 37) + 91) ^ (a >> 2));
  endfunction

  // synchronous storage array, computed contents
  always_ff @(posedge clk) mem_rdata <= mem_val(int'(mem_addr));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [7:0] b;
    if (m_sync > 0) begin
      m_sync--;
      e_oe = 1'b0;
      e_req = "R1";
    end else if (m_pos < 8) begin
      b = mem_val(m_addr);
      e_bit = b[7 - m_pos];
      e_oe = 1'b1;
      e_req = (m_first != 0) ? "R2" : "R4";
      m_first = 0;
      m_pos++;
    end else begin
      e_oe = 1'b0;
      e_req = "R5";
      m_pos = 0;
      m_addr = (m_addr + 1) % 128;
    end
  endtask

  // one tx_clk pulse, then compare with the model
  task automatic pulse_chk();
    @(negedge clk) tx_clk = 1'b1;
    repeat (4) @(negedge clk);
    model_step();
    check(e_req, int'(sda_oe), int'(e_oe));
    if (e_oe) check(e_req, int'(sda_out), int'(e_bit));
    check("R6", int'(mem_addr), m_addr);
    tx_clk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'(sda_oe), 0);
    check("R6", int'(mem_addr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 9; i++) pulse_chk();   // R1 silent sync
    pulse_chk();                               // R2 first MSB
    for (int i = 0; i < 17; i++) pulse_chk();  // R4 R5 two bytes

    // R3: no edge, nothing moves even over many cycles
    begin
      logic so, soe; logic [6:0] sa;
      so = sda_out; soe = sda_oe; sa = mem_addr;
      @(negedge clk) tx_clk = 1'b1;
      repeat (30) @(negedge clk);
      model_step();
      check("R3", int'(sda_oe), int'(e_oe));
      if (e_oe) check("R3", int'(sda_out), int'(e_bit));
      repeat (20) @(negedge clk);
      check("R3", int'(sda_oe), int'(e_oe));
      tx_clk = 1'b0;
      repeat (20) @(negedge clk);
      check("R3", int'(mem_addr), m_addr);
      if (soe && sa != mem_addr) check("R3", int'(so), int'(so));
    end

    // R6: run through the 7Fh -> 00h wrap
    while (!(m_addr == 0 && m_pos == 0 && mem_addr == 7'd0 && checks > 100))
      pulse_chk();
    check("R6", int'(mem_addr), 0);
    for (int i = 0; i < 12; i++) pulse_chk();

    // R7: disable mid-byte
    @(negedge clk) stream_en = 1'b0;
    #1 check("R7", int'(sda_oe), 0);
    begin
      logic [6:0] held;
      held = mem_addr;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk) tx_clk = 1'b1;
        repeat (4) @(negedge clk);
        check("R7", int'(sda_oe), 0);
        tx_clk = 1'b0;
        repeat (3) @(negedge clk);
        check("R7", int'(mem_addr), int'(held));
      end
    end

    // R8: re-enable restarts at MSB of address 0
    @(negedge clk) stream_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", int'(sda_oe), 0);
    m_sync = 0; m_pos = 0; m_addr = 0;
    pulse_chk();
    check("R8", int'(sda_oe), 1);
    check("R8", int'(sda_out), int'(mem_val(0) >> 7));
    for (int i = 0; i < 26; i++) pulse_chk();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule